// File: doc/BRIEF.md
# Accelerometer SPI Register and Conversion Slave

This block is the serial front end of a three-axis sensing core. A host drives a four-wire SPI link in mode 0: chip select active low, clock idle low. The host can read or write an 8-bit register bank, or it can request an acceleration sample and read it back. The SPI pins are sampled by a faster system clock. Each edge of the serial clock is found inside the block, and every action takes place in the system clock domain. The register bank itself sits outside the block and is reached through a single address port, a write strobe and a combinational read-data input.

Every transfer begins with a command byte. Its top bit chooses read or write, and its low four bits choose a register. A read of one of the six axis byte addresses also asks the converter for a new sample of that axis. The host then keeps the serial clock low for long enough for the conversion to finish. After that it clocks out the 12-bit result, left-justified in two bytes. If the host keeps clocking, the block streams the remaining axis bytes and then the three control registers, until chip select rises.

Top module: `spi_acc_slave`

## Requirements
- R1: In the command byte, bit 7 = 1 selects a read and bit 7 = 0 selects a write. Bits 3..0 select the register address, and bits 6..4 are ignored.
- R2: A write transfer is a command byte followed by one data byte. The block issues exactly one `reg_we` pulse carrying that address and data. Any further bytes in the same transfer cause no write.
- R3: SDI is captured on the rising edge of SCLK. SDO changes only after a falling edge. Both directions are MSB first.
- R4: `sdo_en` is low, and `sdo` is high impedance, while nCS is high, during the command byte, and for the whole of a write transfer. It is high during the data bytes of a read.
- R5: A read of an address from 6 to 15 returns `reg_rdata` for that address in the byte after the command.
- R6: A read of address 0..5 raises `conv_start` for exactly one cycle, with `conv_axis` = address bits 2..1 (X=0, Y=1, Z=2). A read of any other address never starts a conversion.
- R7: For axis data, an even address returns result bits 11..4. An odd address returns result bits 3..0 followed by four zero bits.
- R8: If `conv_done` arrives before the rising edge of the first data bit, the returned bytes carry the new result.
- R9: If the conversion is still running at that edge, the previously stored result for that axis is returned. A result that completes later is stored and returned by later reads.
- R10: During a read, each further byte auto-increments the address. After 5 comes 12, then 13, then 14, and the address stays at 14. Any other address advances by one.
- R11: Raising nCS ends the transfer at once. A partial write byte is discarded, and the next byte after nCS falls again is taken as a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCLK rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| ncs_i | input | 1 | SPI chip select, active low |
| sclk_i | input | 1 | SPI serial clock |
| sdi_i | input | 1 | SPI data from host |
| sdo | output | 1 | SPI data to host, high impedance when not driven |
| sdo_en | output | 1 | Pad enable for `sdo` |
| reg_addr | output | 4 | Register bank address, shared by reads and writes |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data for `reg_addr`, combinational |
| conv_start | output | 1 | One-cycle conversion request |
| conv_axis | output | 2 | Axis of the requested conversion |
| conv_done | input | 1 | One-cycle conversion completion |
| conv_result | input | 12 | Conversion result, valid with `conv_done` |

## Verification
Each serial edge passes through a two-stage synchroniser and one register. As a result, a new SDO bit, a `conv_start` pulse and a `reg_we` pulse each appear three system cycles after the SCLK edge that causes them. The bench moves SCLK only every eight system cycles and samples SDO on the last cycle before the next rising edge, so every value it reads has settled. Conversion latency is set in the bench's converter model. For the fresh-result case it is chosen to end within the hold time, and for the stale case to end well after it. The bench then waits for the late result before it reads that axis again.

// File: rtl/spi_acc_pkg.sv
package spi_acc_pkg;

  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned RES_W     = 12;
  localparam int unsigned NUM_AXES  = 3;
  localparam int unsigned PTR_W     = 4;
  localparam int unsigned BITCNT_W  = $clog2(BYTE_W);

  // Streaming order: axis bytes, then jump to the control block, then hold.
  localparam logic [PTR_W-1:0] AXIS_LAST  = 4'd5;
  localparam logic [PTR_W-1:0] CTRL_FIRST = 4'hC;
  localparam logic [PTR_W-1:0] CTRL_LAST  = 4'hE;

  typedef logic [RES_W-1:0] result_t;

  function automatic logic [PTR_W-1:0] ptr_advance(input logic [PTR_W-1:0] p);
    if (p == AXIS_LAST)      return CTRL_FIRST;
    else if (p == CTRL_LAST) return CTRL_LAST;
    else                     return p + 1'b1;
  endfunction

  // Left-justified result: high byte = bits 11..4, low byte = bits 3..0 + pad.
  function automatic logic [BYTE_W-1:0] result_byte(input result_t r, input logic low_half);
    return low_half ? {r[3:0], 4'b0000} : r[11:4];
  endfunction

endpackage

// File: rtl/spi_acc_sync.sv
module spi_acc_sync #(
  parameter int unsigned       WIDTH   = 3,
  parameter int unsigned       STAGES  = 2,
  parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= RST_VAL;
        else        stage_q[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/spi_acc_result_store.sv
module spi_acc_result_store
  import spi_acc_pkg::*;
#(
  parameter int unsigned AXES   = NUM_AXES,
  parameter int unsigned AXIS_W = $clog2(AXES)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [AXIS_W-1:0]          wr_axis,
  input  result_t                    wr_data,
  output logic [AXES-1:0][RES_W-1:0] rd_data
);

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    logic hit;
    assign hit = wr_en && (wr_axis == AXIS_W'(a));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   rd_data[a] <= '0;
      else if (hit) rd_data[a] <= wr_data;
    end
  end

endmodule

// File: rtl/spi_acc_slave.sv
module spi_acc_slave
  import spi_acc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ncs_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  output logic              sdo,
  output logic              sdo_en,
  output logic [PTR_W-1:0]  reg_addr,
  output logic              reg_we,
  output logic [BYTE_W-1:0] reg_wdata,
  input  logic [BYTE_W-1:0] reg_rdata,
  output logic              conv_start,
  output logic [1:0]        conv_axis,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_result
);

  localparam int unsigned         AXIS_W   = $clog2(NUM_AXES);
  localparam logic [BITCNT_W-1:0] BIT_LAST = BITCNT_W'(BYTE_W - 1);

  // Reset: asserted asynchronously, released on the clock.
  logic rst_n_s;
  spi_acc_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_n_s)
  );

  logic cs_s, sck_s, sdi_s;
  spi_acc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) i_pin_sync (
    .clk(clk), .rst_n(rst_n_s), .d({ncs_i, sclk_i, sdi_i}), .q({cs_s, sck_s, sdi_s})
  );

  logic                 sck_d;
  logic                 sck_rise, sck_fall;
  logic [BITCNT_W-1:0]  bit_cnt_q, bit_cnt_d;
  logic                 first_q, first_d;
  logic                 rd_q, rd_d;
  logic                 wr_done_q, wr_done_d;
  logic                 pend_q, pend_d;
  logic                 loaded_q, loaded_d;
  logic [PTR_W-1:0]     ptr_q, ptr_d;
  logic [PTR_W-1:0]     txptr_q, txptr_d;
  logic [BYTE_W-2:0]    rx_q, rx_d;
  logic [BYTE_W-1:0]    tx_q, tx_d;
  logic [AXIS_W-1:0]    axis_q, axis_d;
  logic [BYTE_W-1:0]    wdata_q, wdata_d;
  logic                 we_q, we_d;
  logic                 start_q, start_d;
  logic [BYTE_W-1:0]    rx_byte;

  assign sck_rise = ~cs_s &  sck_s & ~sck_d;
  assign sck_fall = ~cs_s & ~sck_s &  sck_d;
  assign rx_byte  = {rx_q, sdi_s};

  // Stored per-axis results, with a bypass for a result landing this cycle.
  logic [NUM_AXES-1:0][RES_W-1:0] stored, res_eff;
  spi_acc_result_store #(.AXES(NUM_AXES), .AXIS_W(AXIS_W)) i_store (
    .clk(clk), .rst_n(rst_n_s), .wr_en(conv_done), .wr_axis(axis_q),
    .wr_data(conv_result), .rd_data(stored)
  );

  always_comb begin
    res_eff = stored;
    if (conv_done && (axis_q < AXIS_W'(NUM_AXES))) res_eff[axis_q] = conv_result;
  end

  logic [BYTE_W-1:0] load_byte, reload_byte;
  assign load_byte   = (ptr_q <= AXIS_LAST) ? result_byte(res_eff[ptr_q[2:1]], ptr_q[0])
                                            : reg_rdata;
  assign reload_byte = result_byte(res_eff[txptr_q[2:1]], txptr_q[0]);

  // Next-state logic
  always_comb begin
    bit_cnt_d = bit_cnt_q;
    first_d   = first_q;
    rd_d      = rd_q;
    wr_done_d = wr_done_q;
    pend_d    = pend_q;
    loaded_d  = loaded_q;
    ptr_d     = ptr_q;
    txptr_d   = txptr_q;
    rx_d      = rx_q;
    tx_d      = tx_q;
    axis_d    = axis_q;
    wdata_d   = wdata_q;
    we_d      = 1'b0;
    start_d   = 1'b0;
    if (cs_s) begin
      bit_cnt_d = '0;
      first_d   = 1'b1;
      rd_d      = 1'b0;
      wr_done_d = 1'b0;
      pend_d    = 1'b0;
      loaded_d  = 1'b0;
    end else begin
      if (sck_rise) begin
        rx_d      = rx_byte[BYTE_W-2:0];
        bit_cnt_d = bit_cnt_q + 1'b1;
        pend_d    = 1'b0;
        if (bit_cnt_q == BIT_LAST) begin
          if (first_q) begin
            first_d = 1'b0;
            rd_d    = rx_byte[BYTE_W-1];
            ptr_d   = rx_byte[PTR_W-1:0];
            if (rx_byte[BYTE_W-1] && (rx_byte[PTR_W-1:0] <= AXIS_LAST)) begin
              start_d = 1'b1;
              axis_d  = rx_byte[AXIS_W:1];
              pend_d  = 1'b1;
            end
          end else if (!rd_q && !wr_done_q) begin
            we_d      = 1'b1;
            wdata_d   = rx_byte;
            wr_done_d = 1'b1;
          end
        end
      end
      if (sck_fall && rd_q) begin
        if (bit_cnt_q == '0) begin
          tx_d     = load_byte;
          txptr_d  = ptr_q;
          ptr_d    = ptr_advance(ptr_q);
          loaded_d = 1'b1;
        end else begin
          tx_d = {tx_q[BYTE_W-2:0], 1'b0};
        end
      end else if (pend_q && loaded_q && conv_done && (txptr_q <= AXIS_LAST)) begin
        tx_d = reload_byte;
      end
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      sck_d     <= 1'b0;
      bit_cnt_q <= '0;
      first_q   <= 1'b1;
      rd_q      <= 1'b0;
      wr_done_q <= 1'b0;
      pend_q    <= 1'b0;
      loaded_q  <= 1'b0;
      ptr_q     <= '0;
      txptr_q   <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      axis_q    <= '0;
      wdata_q   <= '0;
      we_q      <= 1'b0;
      start_q   <= 1'b0;
    end else begin
      sck_d     <= sck_s;
      bit_cnt_q <= bit_cnt_d;
      first_q   <= first_d;
      rd_q      <= rd_d;
      wr_done_q <= wr_done_d;
      pend_q    <= pend_d;
      loaded_q  <= loaded_d;
      ptr_q     <= ptr_d;
      txptr_q   <= txptr_d;
      rx_q      <= rx_d;
      tx_q      <= tx_d;
      axis_q    <= axis_d;
      wdata_q   <= wdata_d;
      we_q      <= we_d;
      start_q   <= start_d;
    end
  end

  assign sdo_en     = ~ncs_i & rd_q & loaded_q;
  assign sdo        = sdo_en ? tx_q[BYTE_W-1] : 1'bz;
  assign reg_addr   = ptr_q;
  assign reg_we     = we_q;
  assign reg_wdata  = wdata_q;
  assign conv_start = start_q;
  assign conv_axis  = 2'(axis_q);

endmodule

// File: rtl/spi_acc_slave_chk.sv
module spi_acc_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_s,
  input logic       reg_we,
  input logic       conv_start,
  input logic [1:0] conv_axis,
  input logic       sdo_en
);

  // R6: a conversion request lasts a single cycle
  a_r6_single_start: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  // R6: only X, Y or Z may be requested
  a_r6_axis_range: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (conv_axis < 2'd3));

  // R2: one write strobe per write
  a_r2_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R4: a write transfer never drives SDO
  a_r4_quiet_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> !sdo_en);

  // R11: a deselected slave issues no request
  a_r11_idle_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (!reg_we && !conv_start));

endmodule

bind spi_acc_slave spi_acc_slave_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .reg_we(reg_we),
  .conv_start(conv_start), .conv_axis(conv_axis), .sdo_en(sdo_en)
);

// File: tb/test_spi_acc_slave.sv
module test_spi_acc_slave;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;

  logic        clk = 1'b0;
  logic        rst_n, ncs, sclk, sdi;
  logic        sdo, sdo_en, reg_we, conv_start, conv_done;
  logic [3:0]  reg_addr;
  logic [7:0]  reg_wdata, reg_rdata;
  logic [1:0]  conv_axis;
  logic [11:0] conv_result;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_acc_slave i_spi_acc_slave (
    .clk(clk), .rst_n(rst_n), .ncs_i(ncs), .sclk_i(sclk), .sdi_i(sdi),
    .sdo(sdo), .sdo_en(sdo_en), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .conv_start(conv_start),
    .conv_axis(conv_axis), .conv_done(conv_done), .conv_result(conv_result)
  );

  // Register bank model
  logic [7:0] mem [16];
  int we_count;
  assign reg_rdata = mem[reg_addr];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] <= 8'(8'h40 + i);
      we_count <= 0;
    end else if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
      we_count      <= we_count + 1;
    end
  end

  // Converter model
  logic [11:0] conv_val [3];
  int          conv_lat;
  int          conv_cnt, start_count;
  logic        busy;
  logic [1:0]  cur_axis, last_axis;
  always @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; conv_done <= 1'b0; conv_cnt <= 0; conv_result <= '0;
      start_count <= 0; cur_axis <= '0; last_axis <= '0;
    end else begin
      conv_done <= 1'b0;
      if (conv_start) begin
        busy <= 1'b1; conv_cnt <= 0; cur_axis <= conv_axis;
        last_axis <= conv_axis; start_count <= start_count + 1;
      end else if (busy) begin
        if (conv_cnt >= conv_lat) begin
          conv_done <= 1'b1; conv_result <= conv_val[cur_axis]; busy <= 1'b0;
        end else conv_cnt <= conv_cnt + 1;
      end
    end
  end

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bits(input logic [7:0] mo, input int nb,
                          output logic [7:0] mi, output logic en_any);
    mi = '0; en_any = 1'b0;
    for (int i = 7; i > 7 - nb; i--) begin
      sdi = mo[i];
      cyc(HALF);
      mi[i]  = sdo_en ? sdo : 1'b0;
      en_any = en_any | sdo_en;
      sclk = 1'b1;
      cyc(HALF);
      sclk = 1'b0;
    end
  endtask

  task automatic spi_byte(input logic [7:0] mo, output logic [7:0] mi, output logic en_any);
    spi_bits(mo, 8, mi, en_any);
  endtask

  task automatic cs_low();
    ncs = 1'b0; cyc(HALF);
  endtask

  task automatic cs_high();
    cyc(HALF); ncs = 1'b1; cyc(4*HALF);
  endtask

  task automatic read_reg(input logic [7:0] cmd, output logic [7:0] val);
    logic [7:0] d; logic e;
    cs_low();
    spi_byte(cmd, d, e);
    spi_byte(8'h00, val, e);
    cs_high();
  endtask

  // {command, data sent, data expected}
  localparam logic [23:0] VEC [9] = '{
    24'h88_00_48, 24'h0A_5A_00, 24'h8A_00_5A, 24'hFA_00_5A, 24'h0C_C3_00,
    24'h8C_00_C3, 24'h7D_1E_00, 24'h8D_00_1E, 24'h8E_00_4E
  };

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    report();
  end

  initial begin
    logic [7:0] rx; logic en;
    int sc0, we0;
    rst_n = 1'b0; ncs = 1'b1; sclk = 1'b0; sdi = 1'b0; conv_lat = 50;
    conv_val[0] = '0; conv_val[1] = '0; conv_val[2] = '0;
    cyc(5); rst_n = 1'b1; cyc(8);

    // Reset state
    chk("R4 reset sdo_en", 32'(sdo_en), 0);
    chk("R2 reset reg_we", 32'(reg_we), 0);
    chk("R6 reset conv_start", 32'(conv_start), 0);

    // Table: register writes and reads
    for (int v = 0; v < 9; v++) begin
      cs_low();
      spi_byte(VEC[v][23:16], rx, en);
      chk("R4 command byte not driven", 32'(en), 0);
      spi_byte(VEC[v][15:8], rx, en);
      cs_high();
      if (VEC[v][23]) begin
        chk("R1 R3 R5 read data", 32'(rx), 32'(VEC[v][7:0]));
        chk("R4 read data driven", 32'(en), 1);
      end else begin
        chk("R2 R4 write not driven", 32'(en), 0);
      end
    end
    chk("R6 register reads start nothing", start_count, 0);

    // X conversion, done during hold, then stream
    conv_val[0] = 12'hABC; conv_lat = 50;
    sc0 = start_count;
    cs_low();
    spi_byte(8'h80, rx, en);
    cyc(200);
    chk("R6 one start", start_count, sc0 + 1);
    chk("R6 axis X", 32'(last_axis), 0);
    spi_byte(8'h00, rx, en); chk("R7 R8 X high", 32'(rx), 32'hAB);
    spi_byte(8'h00, rx, en); chk("R7 R8 X low", 32'(rx), 32'hC0);
    spi_byte(8'h00, rx, en); chk("R10 Y high", 32'(rx), 32'h00);
    spi_byte(8'h00, rx, en); chk("R10 Y low", 32'(rx), 32'h00);
    spi_byte(8'h00, rx, en); chk("R10 Z high", 32'(rx), 32'h00);
    spi_byte(8'h00, rx, en); chk("R10 Z low", 32'(rx), 32'h00);
    spi_byte(8'h00, rx, en); chk("R10 ctrl 0xC", 32'(rx), 32'hC3);
    spi_byte(8'h00, rx, en); chk("R10 ctrl 0xD", 32'(rx), 32'h1E);
    spi_byte(8'h00, rx, en); chk("R10 ctrl 0xE", 32'(rx), 32'h4E);
    spi_byte(8'h00, rx, en); chk("R10 hold at 0xE", 32'(rx), 32'h4E);
    cs_high();

    // Y conversion with immediate completion
    conv_val[1] = 12'h123; conv_lat = 0;
    cs_low();
    spi_byte(8'h82, rx, en);
    cyc(20);
    chk("R6 axis Y", 32'(last_axis), 1);
    spi_byte(8'h00, rx, en); chk("R8 Y high", 32'(rx), 32'h12);
    spi_byte(8'h00, rx, en); chk("R7 Y low", 32'(rx), 32'h30);
    cs_high();

    // Start at Z low byte
    conv_val[2] = 12'h9F7; conv_lat = 50;
    cs_low();
    spi_byte(8'h85, rx, en);
    cyc(200);
    chk("R6 axis Z", 32'(last_axis), 2);
    spi_byte(8'h00, rx, en); chk("R7 Z low first", 32'(rx), 32'h70);
    spi_byte(8'h00, rx, en); chk("R10 jump to 0xC", 32'(rx), 32'hC3);
    cs_high();

    // Late completion returns stored value
    conv_val[0] = 12'h456; conv_lat = 2000;
    cs_low();
    spi_byte(8'h80, rx, en);
    cyc(30);
    spi_byte(8'h00, rx, en); chk("R9 stale X high", 32'(rx), 32'hAB);
    cs_high();
    cyc(2100);
    conv_val[0] = 12'h777;
    cs_low();
    spi_byte(8'h80, rx, en);
    cyc(30);
    spi_byte(8'h00, rx, en); chk("R9 late result kept high", 32'(rx), 32'h45);
    spi_byte(8'h00, rx, en); chk("R9 late result kept low", 32'(rx), 32'h60);
    cs_high();
    cyc(2100);

    // Abort in the middle of a read, then a new command
    cs_low();
    spi_byte(8'h8A, rx, en);
    spi_bits(8'h00, 4, rx, en);
    cs_high();
    cs_low();
    spi_byte(8'h8D, rx, en);
    chk("R11 new command byte not driven", 32'(en), 0);
    spi_byte(8'h00, rx, en);
    chk("R11 read after abort", 32'(rx), 32'h1E);
    cs_high();

    // Abort in the middle of a write
    we0 = we_count;
    cs_low();
    spi_byte(8'h0B, rx, en);
    spi_bits(8'hFF, 3, rx, en);
    cs_high();
    chk("R11 aborted write no strobe", we_count, we0);
    read_reg(8'h8B, rx);
    chk("R11 aborted write register intact", 32'(rx), 32'h4B);

    // Extra bytes after a write
    we0 = we_count;
    cs_low();
    spi_byte(8'h09, rx, en);
    spi_byte(8'h11, rx, en);
    spi_byte(8'h22, rx, en);
    cs_high();
    chk("R2 single strobe", we_count, we0 + 1);
    read_reg(8'h89, rx);
    chk("R2 first data kept", 32'(rx), 32'h11);
    read_reg(8'h8A, rx);
    chk("R2 neighbour untouched", 32'(rx), 32'h5A);

    chk("R4 idle after tests", 32'(sdo_en), 0);
    report();
  end

endmodule